// File: doc/BRIEF.md
# Register Hazard Tracking Matrix

This block keeps a bit matrix with one row for each function unit and one column for each architectural register. When an instruction issues to a unit, that unit's row records, in unary form, the registers the instruction will read and the register it will write. Because every register is a column, checking whether a row touches a register is a single AND. Whether a register is free of pending readers or writers is an OR down its column, so the "no hazard" condition is the complement of that OR.

At issue the block takes, for each slot of the issue window, a one-hot unit select, a source-register mask and a one-hot destination. It answers at once, in the same cycle, in two ways. It accepts or refuses the slot, refusing on a write-after-write clash. It also produces the two unit-dependency vectors that a unit-to-unit dependency matrix needs for the issuing instruction. Later slots in the window see the registers claimed by earlier accepted slots as though those earlier slots already held their rows. Units release their read bits when their operands have been read, and their write bit when their result has been written.

Top module: `reg_hazard_matrix`

## Requirements
- R1: During and right after reset, `rd_pend` and `wr_pend` are all zero, and with no slot valid, `issue_ok`, `dep_wr` and `dep_rd` are zero. Reset is asynchronous and active low.
- R2: When slot k is accepted (`issue_ok[k]`=1), the row of the unit selected by `issue_fu_oh[k]` (bit i = unit i) takes `issue_src_oh[k]` as its read bits and `issue_dst_oh[k]` as its write bits. Bit j of each register vector is register j. The change shows on `rd_pend`/`wr_pend` after the next rising clock edge.
- R3: A valid slot whose destination has its `wr_pend` bit set is refused (`issue_ok[k]`=0), and the stored matrix is left unchanged. Once the old writer clears, the same issue is accepted.
- R4: `rd_pend[j]` is the OR of register j's read bit over all rows, and `wr_pend[j]` is the same for the write bits. A register read by several units stays read-pending until every one of them has released it.
- R5: `rd_done[i]` clears unit i's read bits, and `wr_done[i]` clears its write bits, at the next edge. Other rows and the other half of the row are unaffected.
- R6: `dep_wr[k]` has bit i set when unit i's row holds a write bit in any of slot k's source columns (read-after-write).
- R7: `dep_rd[k]` has bit i set when unit i's row holds a read bit in slot k's destination column (write-after-read). Such a dependency does not refuse the issue.
- R8: For slot k>0, the matrix used for the hazard check and for the dependency vectors includes every accepted earlier slot's sources and destination, placed in the row of that slot's unit. A destination clash with an earlier slot of the same window refuses the later slot.
- R9: Slots issue in order. If a valid slot is refused, every later slot in the same window is refused.
- R10: If a unit is issued to in the same cycle as its `rd_done` or `wr_done`, the new issue's bits are stored.
- R11: `dep_wr[k]` and `dep_rd[k]` are zero whenever slot k is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | ISSUE_W | Per-slot issue request |
| issue_fu_oh | input | ISSUE_W x NUM_FU | Per-slot one-hot target unit |
| issue_src_oh | input | ISSUE_W x NUM_REG | Per-slot unary source-register mask |
| issue_dst_oh | input | ISSUE_W x NUM_REG | Per-slot one-hot destination (zero for none) |
| rd_done | input | NUM_FU | Per-unit operands-read release |
| wr_done | input | NUM_FU | Per-unit result-written release |
| issue_ok | output | ISSUE_W | Per-slot issue accepted |
| dep_wr | output | ISSUE_W x NUM_FU | Per-slot units that must write before this slot reads |
| dep_rd | output | ISSUE_W x NUM_FU | Per-slot units that must read before this slot writes |
| rd_pend | output | NUM_REG | Per-register read pending |
| wr_pend | output | NUM_REG | Per-register write pending |

## Verification
On every cycle the assertions check four things: that no register column ever holds two writers, that an accepted slot's destination and sources appear as pending one edge later, that a write clash always refuses the slot and that a refused slot blocks the later ones. They also check that the release strobes empty a row unless an issue to that unit overrides them in the same cycle. The exact content of the dependency vectors, the way a window slot inherits claims from an earlier slot, and the persistence of a read-pending bit shared by several readers depend on particular sequences of issues and releases. Only the bench's scenarios, which compare against values worked out by hand, can show these.

// File: rtl/hzm_pkg.sv
package hzm_pkg;
   localparam int unsigned HZM_NUM_FU   = 8;
   localparam int unsigned HZM_NUM_REG  = 32;
   localparam int unsigned HZM_ISSUE_W  = 2;
endpackage

// File: rtl/hzm_col_or.sv
module hzm_col_or #(
   parameter int unsigned ROWS = 8,
   parameter int unsigned COLS = 32
) (
   input  logic [ROWS-1:0][COLS-1:0] mat_i,
   output logic [COLS-1:0]           any_o
);
   always_comb begin
      any_o = '0;
      for (int r = 0; r < ROWS; r++) begin
         any_o = any_o | mat_i[r];
      end
   end
endmodule

// File: rtl/hzm_row.sv
module hzm_row #(
   parameter int unsigned NUM_REG = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_i,
   input  logic [NUM_REG-1:0] set_rd_i,
   input  logic [NUM_REG-1:0] set_wr_i,
   input  logic               clr_rd_i,
   input  logic               clr_wr_i,
   output logic [NUM_REG-1:0] rd_o,
   output logic [NUM_REG-1:0] wr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_o <= '0;
         wr_o <= '0;
      end else if (set_i) begin
         rd_o <= set_rd_i;
         wr_o <= set_wr_i;
      end else begin
         if (clr_rd_i) rd_o <= '0;
         if (clr_wr_i) wr_o <= '0;
      end
   end

   // R5
   rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_rd_i && !set_i) |=> (rd_o == '0));
   // R5
   wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr_i && !set_i) |=> (wr_o == '0));
   // R5
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_wr_i && !set_i) |=> $stable(wr_o));
   // R10
   issue_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> (rd_o == $past(set_rd_i) && wr_o == $past(set_wr_i)));
endmodule

// File: rtl/hzm_slot.sv
module hzm_slot #(
   parameter int unsigned NUM_FU  = 8,
   parameter int unsigned NUM_REG = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            valid_i,
   input  logic                            go_i,
   input  logic [NUM_FU-1:0]               fu_i,
   input  logic [NUM_REG-1:0]              src_i,
   input  logic [NUM_REG-1:0]              dst_i,
   input  logic [NUM_FU-1:0][NUM_REG-1:0]  mat_rd_i,
   input  logic [NUM_FU-1:0][NUM_REG-1:0]  mat_wr_i,
   output logic                            ok_o,
   output logic [NUM_FU-1:0]               dep_wr_o,
   output logic [NUM_FU-1:0]               dep_rd_o,
   output logic [NUM_FU-1:0][NUM_REG-1:0]  mat_rd_o,
   output logic [NUM_FU-1:0][NUM_REG-1:0]  mat_wr_o
);
   logic [NUM_REG-1:0] wr_seen;
   logic               waw_hit;

   hzm_col_or #(.ROWS(NUM_FU), .COLS(NUM_REG)) u_wr_seen (
      .mat_i (mat_wr_i),
      .any_o (wr_seen)
   );

   assign waw_hit = |(dst_i & wr_seen);
   assign ok_o    = valid_i & go_i & ~waw_hit;

   always_comb begin
      for (int f = 0; f < NUM_FU; f++) begin
         dep_wr_o[f] = ok_o & (|(mat_wr_i[f] & src_i));
         dep_rd_o[f] = ok_o & (|(mat_rd_i[f] & dst_i));
         mat_rd_o[f] = (ok_o && fu_i[f]) ? src_i : mat_rd_i[f];
         mat_wr_o[f] = (ok_o && fu_i[f]) ? dst_i : mat_wr_i[f];
      end
   end

   // R11
   dep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ok_o |-> (dep_wr_o == '0 && dep_rd_o == '0));
endmodule

// File: rtl/reg_hazard_matrix.sv
module reg_hazard_matrix #(
   parameter int unsigned NUM_FU  = hzm_pkg::HZM_NUM_FU,
   parameter int unsigned NUM_REG = hzm_pkg::HZM_NUM_REG,
   parameter int unsigned ISSUE_W = hzm_pkg::HZM_ISSUE_W
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ISSUE_W-1:0]               issue_valid,
   input  logic [ISSUE_W-1:0][NUM_FU-1:0]   issue_fu_oh,
   input  logic [ISSUE_W-1:0][NUM_REG-1:0]  issue_src_oh,
   input  logic [ISSUE_W-1:0][NUM_REG-1:0]  issue_dst_oh,
   input  logic [NUM_FU-1:0]                rd_done,
   input  logic [NUM_FU-1:0]                wr_done,
   output logic [ISSUE_W-1:0]               issue_ok,
   output logic [ISSUE_W-1:0][NUM_FU-1:0]   dep_wr,
   output logic [ISSUE_W-1:0][NUM_FU-1:0]   dep_rd,
   output logic [NUM_REG-1:0]               rd_pend,
   output logic [NUM_REG-1:0]               wr_pend
);
   localparam int unsigned LAST = ISSUE_W - 1;

   if (NUM_FU < 2 || NUM_REG < 2 || ISSUE_W < 1) begin : g_bad_cfg
      $error("reg_hazard_matrix: NUM_FU and NUM_REG must be >= 2, ISSUE_W >= 1");
   end

   logic [NUM_FU-1:0][NUM_REG-1:0] row_rd;
   logic [NUM_FU-1:0][NUM_REG-1:0] row_wr;
   logic [NUM_FU-1:0]              row_set;

   for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
      logic                           go;
      logic                           ok;
      logic [NUM_FU-1:0][NUM_REG-1:0] in_rd;
      logic [NUM_FU-1:0][NUM_REG-1:0] in_wr;
      logic [NUM_FU-1:0][NUM_REG-1:0] out_rd;
      logic [NUM_FU-1:0][NUM_REG-1:0] out_wr;

      if (k == 0) begin : g_head
         assign go    = 1'b1;
         assign in_rd = row_rd;
         assign in_wr = row_wr;
      end else begin : g_tail
         assign go    = g_slot[k-1].go & (g_slot[k-1].ok | ~issue_valid[k-1]);
         assign in_rd = g_slot[k-1].out_rd;
         assign in_wr = g_slot[k-1].out_wr;

         // R9
         in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_valid[k-1] && !issue_ok[k-1]) |-> !issue_ok[k]);
      end

      hzm_slot #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .valid_i  (issue_valid[k]),
         .go_i     (go),
         .fu_i     (issue_fu_oh[k]),
         .src_i    (issue_src_oh[k]),
         .dst_i    (issue_dst_oh[k]),
         .mat_rd_i (in_rd),
         .mat_wr_i (in_wr),
         .ok_o     (ok),
         .dep_wr_o (dep_wr[k]),
         .dep_rd_o (dep_rd[k]),
         .mat_rd_o (out_rd),
         .mat_wr_o (out_wr)
      );

      assign issue_ok[k] = ok;

      // R2
      dst_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
         issue_ok[k] |=> ((wr_pend & $past(issue_dst_oh[k])) == $past(issue_dst_oh[k])));
      // R2
      src_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
         issue_ok[k] |=> ((rd_pend & $past(issue_src_oh[k])) == $past(issue_src_oh[k])));
      // R3
      waw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (issue_valid[k] && (|(issue_dst_oh[k] & wr_pend))) |-> !issue_ok[k]);
      // R2
      ok_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         issue_ok[k] |-> issue_valid[k]);
   end

   always_comb begin
      row_set = '0;
      for (int k = 0; k < ISSUE_W; k++) begin
         row_set = row_set | (issue_fu_oh[k] & {NUM_FU{issue_ok[k]}});
      end
   end

   for (genvar f = 0; f < NUM_FU; f++) begin : g_row
      hzm_row #(.NUM_REG(NUM_REG)) u_row (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_i    (row_set[f]),
         .set_rd_i (g_slot[LAST].out_rd[f]),
         .set_wr_i (g_slot[LAST].out_wr[f]),
         .clr_rd_i (rd_done[f]),
         .clr_wr_i (wr_done[f]),
         .rd_o     (row_rd[f]),
         .wr_o     (row_wr[f])
      );
   end

   hzm_col_or #(.ROWS(NUM_FU), .COLS(NUM_REG)) u_rd_col (
      .mat_i (row_rd),
      .any_o (rd_pend)
   );

   hzm_col_or #(.ROWS(NUM_FU), .COLS(NUM_REG)) u_wr_col (
      .mat_i (row_wr),
      .any_o (wr_pend)
   );

   for (genvar c = 0; c < NUM_REG; c++) begin : g_col
      logic [NUM_FU-1:0] wcol;
      always_comb begin
         for (int f = 0; f < NUM_FU; f++) wcol[f] = row_wr[f][c];
      end
      // R4
      single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(wcol));
   end
endmodule

// File: tb/reg_hazard_matrix_tb_top.sv
module reg_hazard_matrix_tb_top;
   localparam int NFU = 8;
   localparam int NRG = 32;
   localparam int IW  = 2;

   typedef struct packed {
      logic [1:0]  vld;
      logic [2:0]  fu0;
      logic [2:0]  fu1;
      logic [31:0] src0;
      logic [31:0] dst0;
      logic [31:0] src1;
      logic [31:0] dst1;
      logic [7:0]  rdd;
      logic [7:0]  wrd;
      logic [1:0]  ok;
      logic [7:0]  dw0;
      logic [7:0]  dr0;
      logic [7:0]  dw1;
      logic [7:0]  dr1;
      logic [31:0] rp;
      logic [31:0] wp;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t TBL [NVEC] = '{
      '{2'b11, 3'd0, 3'd1, 32'h6,  32'h8,  32'h8,  32'h10, 8'h00, 8'h00, 2'b11, 8'h00, 8'h00, 8'h01, 8'h00, 32'h0E, 32'h18},
      '{2'b01, 3'd2, 3'd0, 32'h10, 32'h2,  32'h0,  32'h0,  8'h00, 8'h00, 2'b01, 8'h02, 8'h01, 8'h00, 8'h00, 32'h1E, 32'h1A},
      '{2'b11, 3'd3, 3'd4, 32'h0,  32'h8,  32'h0,  32'h20, 8'h00, 8'h00, 2'b00, 8'h00, 8'h00, 8'h00, 8'h00, 32'h1E, 32'h1A},
      '{2'b11, 3'd3, 3'd4, 32'h40, 32'h20, 32'h0,  32'h20, 8'h00, 8'h00, 2'b01, 8'h00, 8'h00, 8'h00, 8'h00, 32'h5E, 32'h3A},
      '{2'b00, 3'd0, 3'd0, 32'h0,  32'h0,  32'h0,  32'h0,  8'h01, 8'h00, 2'b00, 8'h00, 8'h00, 8'h00, 8'h00, 32'h58, 32'h3A},
      '{2'b00, 3'd0, 3'd0, 32'h0,  32'h0,  32'h0,  32'h0,  8'h02, 8'h02, 2'b00, 8'h00, 8'h00, 8'h00, 8'h00, 32'h50, 32'h2A},
      '{2'b11, 3'd5, 3'd6, 32'h40, 32'h0,  32'h40, 32'h0,  8'h00, 8'h00, 2'b11, 8'h00, 8'h00, 8'h00, 8'h00, 32'h50, 32'h2A},
      '{2'b00, 3'd0, 3'd0, 32'h0,  32'h0,  32'h0,  32'h0,  8'h28, 8'h00, 2'b00, 8'h00, 8'h00, 8'h00, 8'h00, 32'h50, 32'h2A},
      '{2'b00, 3'd0, 3'd0, 32'h0,  32'h0,  32'h0,  32'h0,  8'h40, 8'h00, 2'b00, 8'h00, 8'h00, 8'h00, 8'h00, 32'h10, 32'h2A}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [IW-1:0]           issue_valid = '0;
   logic [IW-1:0][NFU-1:0]  issue_fu_oh = '0;
   logic [IW-1:0][NRG-1:0]  issue_src_oh = '0;
   logic [IW-1:0][NRG-1:0]  issue_dst_oh = '0;
   logic [NFU-1:0]          rd_done = '0;
   logic [NFU-1:0]          wr_done = '0;
   logic [IW-1:0]           issue_ok;
   logic [IW-1:0][NFU-1:0]  dep_wr;
   logic [IW-1:0][NFU-1:0]  dep_rd;
   logic [NRG-1:0]          rd_pend;
   logic [NRG-1:0]          wr_pend;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   reg_hazard_matrix #(.NUM_FU(NFU), .NUM_REG(NRG), .ISSUE_W(IW)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .issue_valid  (issue_valid),
      .issue_fu_oh  (issue_fu_oh),
      .issue_src_oh (issue_src_oh),
      .issue_dst_oh (issue_dst_oh),
      .rd_done      (rd_done),
      .wr_done      (wr_done),
      .issue_ok     (issue_ok),
      .dep_wr       (dep_wr),
      .dep_rd       (dep_rd),
      .rd_pend      (rd_pend),
      .wr_pend      (wr_pend)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input int i);
      case (i)
         0: return "R2 R6 R8";
         1: return "R6 R7";
         2: return "R3 R9 R11";
         3: return "R8";
         4, 5: return "R5";
         default: return "R4";
      endcase
   endfunction

   // Called just after a rising edge; drives one cycle and checks both
   // the same-cycle answers and the state seen after the next edge.
   task automatic apply(input vec_t e, input string tag);
      issue_valid     = e.vld;
      issue_fu_oh[0]  = e.vld[0] ? (8'd1 << e.fu0) : 8'd0;
      issue_fu_oh[1]  = e.vld[1] ? (8'd1 << e.fu1) : 8'd0;
      issue_src_oh[0] = e.src0;
      issue_dst_oh[0] = e.dst0;
      issue_src_oh[1] = e.src1;
      issue_dst_oh[1] = e.dst1;
      rd_done         = e.rdd;
      wr_done         = e.wrd;
      #1;
      chk({tag, " issue_ok"}, 32'(issue_ok), 32'(e.ok));
      chk({tag, " dep_wr slot0"}, 32'(dep_wr[0]), 32'(e.dw0));
      chk({tag, " dep_rd slot0"}, 32'(dep_rd[0]), 32'(e.dr0));
      chk({tag, " dep_wr slot1"}, 32'(dep_wr[1]), 32'(e.dw1));
      chk({tag, " dep_rd slot1"}, 32'(dep_rd[1]), 32'(e.dr1));
      @(posedge clk);
      #1;
      issue_valid  = '0;
      issue_fu_oh  = '0;
      issue_src_oh = '0;
      issue_dst_oh = '0;
      rd_done      = '0;
      wr_done      = '0;
      #1;
      chk({tag, " rd_pend"}, rd_pend, e.rp);
      chk({tag, " wr_pend"}, wr_pend, e.wp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog R1 actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      vec_t d;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset held
      chk("R1 rd_pend in reset", rd_pend, 32'h0);
      chk("R1 wr_pend in reset", wr_pend, 32'h0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 rd_pend after reset", rd_pend, 32'h0);
      chk("R1 wr_pend after reset", wr_pend, 32'h0);
      chk("R1 issue_ok idle", 32'(issue_ok), 32'h0);
      chk("R1 dep_wr idle", 32'(dep_wr), 32'h0);
      chk("R1 dep_rd idle", 32'(dep_rd), 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         apply(TBL[i], $sformatf("vec%0d %s", i, tag_of(i)));
      end

      // R10: issue to unit 7 with both releases for unit 7 in the same cycle
      d = '0;
      d.vld = 2'b01; d.fu0 = 3'd7; d.src0 = 32'h200; d.dst0 = 32'h100;
      d.rdd = 8'h80; d.wrd = 8'h80; d.ok = 2'b01;
      d.rp = 32'h210; d.wp = 32'h12A;
      apply(d, "R10 issue beats release");

      // R5: releases alone now empty unit 7's row
      d = '0;
      d.rdd = 8'h80; d.wrd = 8'h80;
      d.rp = 32'h10; d.wp = 32'h2A;
      apply(d, "R5 release unit7");

      // R3: destination r3 still written by unit 0, so refused and no change
      d = '0;
      d.vld = 2'b01; d.fu0 = 3'd4; d.src0 = 32'h2; d.dst0 = 32'h8;
      d.ok = 2'b00; d.rp = 32'h10; d.wp = 32'h2A;
      apply(d, "R3 waw refused");

      // R5: unit 0 releases its write of r3
      d = '0;
      d.wrd = 8'h01; d.rp = 32'h10; d.wp = 32'h22;
      apply(d, "R5 release write unit0");

      // R3: same issue now accepted; R6 source r1 is written by unit 2
      d = '0;
      d.vld = 2'b01; d.fu0 = 3'd4; d.src0 = 32'h2; d.dst0 = 32'h8;
      d.ok = 2'b01; d.dw0 = 8'h04; d.dr0 = 8'h00;
      d.rp = 32'h12; d.wp = 32'h2A;
      apply(d, "R3 R6 retry accepted");

      // R1: reset in mid-run clears everything at once
      rst_n = 1'b0;
      #2;
      chk("R1 rd_pend mid reset", rd_pend, 32'h0);
      chk("R1 wr_pend mid reset", wr_pend, 32'h0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 wr_pend after second reset", wr_pend, 32'h0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule